// File: doc/BRIEF.md
# Slow-Clock Real-Time Counter with Clock-Domain Crossing

This block is an 8-bit timer/counter that a processor programs and reads over a plain register-write port. A mode input chooses the timer clock. When the mode is low, the timer runs on the processor clock. When it is high, the timer runs on a separate slow clock, usually a 32.768 kHz watch oscillator. The timer holds three registers: the counter, a compare value and a two-bit control word. Control bit 0 is run. Control bit 1 enables toggling of the compare output.

In asynchronous mode these registers sit in the slow domain, so the processor never touches them directly:

- **Writes.** Each write is parked in a per-register staging channel on the processor side. The value is passed across with a toggle request/acknowledge handshake, and the channel shows a busy flag until the slow side has acknowledged it. Each channel is a two-state machine. It moves from CH_IDLE to CH_SEND on an accepted write, and from CH_SEND back to CH_IDLE once the acknowledge matches the request.
- **Reads.** The counter is read through a copy held in the processor domain. That copy is reloaded after every rising edge of the slow clock.
- **Events.** Overflow and compare-match events are toggles in the slow domain. Each is synchronized into a flag machine. That machine moves from FLG_CLEAR to FLG_SET on an event, and from FLG_SET back to FLG_CLEAR on a write-one clear or an interrupt acknowledge that does not coincide with a new event.

Top module: `rtc_async_timer`

## Requirements
- R1: While reset is asserted and right after its release, count_rd, every busy flag, both event flags, both interrupt requests and cmp_out are zero.
- R2: A write accepted while the addressed register's busy flag is low raises that busy flag from the next processor cycle. The flag stays high until the slow domain has taken the value in, then returns to zero. wr_sel encodes 0 = counter, 1 = compare, 2 = control; 3 selects nothing.
- R3: A write to a register whose busy flag is high is dropped and does not change the value that is in transit.
- R4: With control bit 0 (run) set, the counter adds one on every timer clock rising edge and wraps from 0xFF to 0x00. A counter write loads the written value at its load edge, with no increment on that edge.
- R5: In asynchronous mode, count_rd shows the counter value from the most recent slow-clock rising edge. While the slow clock is stopped, count_rd keeps its pre-pause value until the next rising slow edge.
- R6: flag_cmp is set when the counter steps onto the compare value. It is seen in the processor domain no earlier than three and no later than four processor cycles after that slow edge, and it stays set until it is cleared.
- R7: flag_ovf is set when the counter wraps from 0xFF to 0x00, and not on the edges before the wrap.
- R8: Each flag is cleared by a one-cycle pulse on its write-one-clear input or on its interrupt-acknowledge input.
- R9: Each interrupt request is high exactly when gie, that source's enable and that source's flag are all high.
- R10: When control bit 1 is set, cmp_out toggles on the slow edge of a compare match. It is not delayed by the processor-domain synchronizers, so it changes before flag_cmp does.
- R11: With async_mode low, the counter runs on clk_cpu and count_rd shows the live counter value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_cpu | input | 1 | Processor clock |
| clk_slow | input | 1 | Slow oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| async_mode | input | 1 | 1 = timer on clk_slow, 0 = timer on clk_cpu |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 counter, 1 compare, 2 control |
| wr_data | input | 8 | Write data; control uses bits 1:0 |
| count_rd | output | 8 | Counter value as seen by the processor |
| busy_cnt | output | 1 | Counter write in transit |
| busy_cmp | output | 1 | Compare write in transit |
| busy_ctl | output | 1 | Control write in transit |
| flag_clr_ovf | input | 1 | Write-one clear of the overflow flag |
| flag_clr_cmp | input | 1 | Write-one clear of the compare flag |
| irq_ack_ovf | input | 1 | Overflow interrupt acknowledge |
| irq_ack_cmp | input | 1 | Compare interrupt acknowledge |
| gie | input | 1 | Global interrupt enable |
| ie_ovf | input | 1 | Overflow interrupt enable |
| ie_cmp | input | 1 | Compare interrupt enable |
| flag_ovf | output | 1 | Overflow flag |
| flag_cmp | output | 1 | Compare-match flag |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmp | output | 1 | Compare interrupt request |
| cmp_out | output | 1 | Compare output, toggled in the timer domain |

## Verification
The bench aims at the timing edges of the crossing:

- **Flag latency.** The compare flag is sampled one cycle before and one cycle after its allowed arrival window. A synchronizer stage too few or too many shows up as an early or missing flag.
- **Load versus increment.** A counter write lands while the counter is running. A design that also increments on the load edge reads one too high.
- **Dropped writes.** A second compare write is issued while the first is still busy. If the second write is accepted, the match moves and flag_cmp stays low.
- **Paused slow clock.** The slow clock is stopped and then restarted. A read copy that tracks the counter without waiting for a slow edge, or that misses the restart, gives the wrong value.
- **Flags and requests.** The wrap, the write-one and acknowledge clears, and gating by gie or a source enable are each driven separately.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    // Register select codes on wr_sel
    typedef enum logic [1:0] {
        SEL_CNT = 2'd0,
        SEL_CMP = 2'd1,
        SEL_CTL = 2'd2
    } rtc_sel_e;

    // Staging channel state
    typedef enum logic {
        CH_IDLE,
        CH_SEND
    } chan_state_e;

    // Processor-side flag state
    typedef enum logic {
        FLG_CLEAR,
        FLG_SET
    } flag_state_e;

    localparam int CTL_W       = 2;
    localparam int CTL_RUN_BIT = 0;
    localparam int CTL_TGL_BIT = 1;
    localparam int NUM_DATA_CH = 2;
    localparam int DCH_CNT     = 0;
    localparam int DCH_CMP     = 1;

endpackage

// File: rtl/rtc_sync2.sv
module rtc_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/rtc_wr_chan.sv
module rtc_wr_chan import rtc_pkg::*; #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] din,
    input  logic         ack_tgl,
    output logic         req_tgl,
    output logic [W-1:0] hold,
    output logic         busy
);
    chan_state_e state, state_nxt;
    logic        ack_s;

    rtc_sync2 u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_tgl),
        .q     (ack_s)
    );

    always_comb begin
        state_nxt = state;
        unique case (state)
            CH_IDLE: if (wr) state_nxt = CH_SEND;
            CH_SEND: if (ack_s == req_tgl) state_nxt = CH_IDLE;
            default: state_nxt = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_nxt;
    end

    // Staging register and request toggle: only an idle channel accepts
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_tgl <= 1'b0;
            hold    <= '0;
        end else if (state == CH_IDLE && wr) begin
            req_tgl <= ~req_tgl;
            hold    <= din;
        end
    end

    assign busy = (state == CH_SEND);
endmodule

// File: rtl/rtc_slow_core.sv
module rtc_slow_core import rtc_pkg::*; #(
    parameter int W = 8
) (
    input  logic                            tclk,
    input  logic                            rst_n,
    input  logic [NUM_DATA_CH-1:0]          data_req,
    input  logic [NUM_DATA_CH-1:0][W-1:0]   data_hold,
    input  logic                            ctl_req,
    input  logic [CTL_W-1:0]                ctl_hold,
    output logic [NUM_DATA_CH-1:0]          data_ack,
    output logic                            ctl_ack,
    output logic [W-1:0]                    cnt_q,
    output logic                            ovf_tgl,
    output logic                            cmp_tgl,
    output logic                            cmp_out
);
    localparam int          NCH   = NUM_DATA_CH + 1;
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [NCH-1:0] req_all, req_s, req_prev, load;
    logic [W-1:0]   cmp_q, cnt_inc;
    logic [CTL_W-1:0] ctl_q;
    logic           run, wrap, match;

    assign req_all = {ctl_req, data_req};

    for (genvar i = 0; i < NCH; i++) begin : g_req
        rtc_sync2 u_req_sync (
            .clk   (tclk),
            .rst_n (rst_n),
            .d     (req_all[i]),
            .q     (req_s[i])
        );
        always_ff @(posedge tclk or negedge rst_n) begin
            if (!rst_n) req_prev[i] <= 1'b0;
            else        req_prev[i] <= req_s[i];
        end
        assign load[i] = req_s[i] ^ req_prev[i];
    end

    // Acknowledge follows the request once the load edge has passed
    assign data_ack = req_prev[NUM_DATA_CH-1:0];
    assign ctl_ack  = req_prev[NUM_DATA_CH];

    assign run     = ctl_q[CTL_RUN_BIT];
    assign cnt_inc = cnt_q + 1'b1;
    assign wrap    = run && !load[DCH_CNT] && (cnt_q == CNT_MAX);
    assign match   = run && !load[DCH_CNT] && (cnt_inc == cmp_q);

    always_ff @(posedge tclk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            cmp_q   <= '0;
            ctl_q   <= '0;
            ovf_tgl <= 1'b0;
            cmp_tgl <= 1'b0;
            cmp_out <= 1'b0;
        end else begin
            if (load[DCH_CNT])        cnt_q <= data_hold[DCH_CNT];
            else if (run)             cnt_q <= cnt_inc;
            if (load[DCH_CMP])        cmp_q <= data_hold[DCH_CMP];
            if (load[NUM_DATA_CH])    ctl_q <= ctl_hold;
            if (wrap)                 ovf_tgl <= ~ovf_tgl;
            if (match)                cmp_tgl <= ~cmp_tgl;
            if (match && ctl_q[CTL_TGL_BIT]) cmp_out <= ~cmp_out;
        end
    end
endmodule

// File: rtl/rtc_flag_unit.sv
module rtc_flag_unit import rtc_pkg::*; (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_tgl,
    input  logic clr_w1,
    input  logic ack,
    output logic flag
);
    flag_state_e state, state_nxt;
    logic        evt_s, evt_prev, evt;

    rtc_sync2 u_evt_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (evt_tgl),
        .q     (evt_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_prev <= 1'b0;
        else        evt_prev <= evt_s;
    end

    assign evt = evt_s ^ evt_prev;

    always_comb begin
        state_nxt = state;
        unique case (state)
            FLG_CLEAR: if (evt) state_nxt = FLG_SET;
            FLG_SET:   if ((clr_w1 || ack) && !evt) state_nxt = FLG_CLEAR;
            default:   state_nxt = FLG_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FLG_CLEAR;
        else        state <= state_nxt;
    end

    assign flag = (state == FLG_SET);
endmodule

// File: rtl/rtc_async_timer.sv
module rtc_async_timer import rtc_pkg::*; #(
    parameter int CNT_W = 8
) (
    input  logic             clk_cpu,
    input  logic             clk_slow,
    input  logic             rst_n,
    input  logic             async_mode,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count_rd,
    output logic             busy_cnt,
    output logic             busy_cmp,
    output logic             busy_ctl,
    input  logic             flag_clr_ovf,
    input  logic             flag_clr_cmp,
    input  logic             irq_ack_ovf,
    input  logic             irq_ack_cmp,
    input  logic             gie,
    input  logic             ie_ovf,
    input  logic             ie_cmp,
    output logic             flag_ovf,
    output logic             flag_cmp,
    output logic             irq_ovf,
    output logic             irq_cmp,
    output logic             cmp_out
);
    logic tclk;
    assign tclk = async_mode ? clk_slow : clk_cpu;

    logic [NUM_DATA_CH-1:0]              data_wr, data_req, data_ack, data_busy;
    logic [NUM_DATA_CH-1:0][CNT_W-1:0]   data_hold;
    logic                                ctl_wr, ctl_req, ctl_ack;
    logic [CTL_W-1:0]                    ctl_hold;
    logic [CNT_W-1:0]                    cnt_q, rd_copy;
    logic                                ovf_tgl, cmp_tgl, slow_s, slow_prev;

    assign data_wr[DCH_CNT] = wr_en && (wr_sel == SEL_CNT);
    assign data_wr[DCH_CMP] = wr_en && (wr_sel == SEL_CMP);
    assign ctl_wr           = wr_en && (wr_sel == SEL_CTL);

    for (genvar i = 0; i < NUM_DATA_CH; i++) begin : g_data_chan
        rtc_wr_chan #(.W(CNT_W)) u_chan (
            .clk     (clk_cpu),
            .rst_n   (rst_n),
            .wr      (data_wr[i]),
            .din     (wr_data),
            .ack_tgl (data_ack[i]),
            .req_tgl (data_req[i]),
            .hold    (data_hold[i]),
            .busy    (data_busy[i])
        );
    end

    rtc_wr_chan #(.W(CTL_W)) u_ctl_chan (
        .clk     (clk_cpu),
        .rst_n   (rst_n),
        .wr      (ctl_wr),
        .din     (wr_data[CTL_W-1:0]),
        .ack_tgl (ctl_ack),
        .req_tgl (ctl_req),
        .hold    (ctl_hold),
        .busy    (busy_ctl)
    );

    assign busy_cnt = data_busy[DCH_CNT];
    assign busy_cmp = data_busy[DCH_CMP];

    rtc_slow_core #(.W(CNT_W)) u_core (
        .tclk      (tclk),
        .rst_n     (rst_n),
        .data_req  (data_req),
        .data_hold (data_hold),
        .ctl_req   (ctl_req),
        .ctl_hold  (ctl_hold),
        .data_ack  (data_ack),
        .ctl_ack   (ctl_ack),
        .cnt_q     (cnt_q),
        .ovf_tgl   (ovf_tgl),
        .cmp_tgl   (cmp_tgl),
        .cmp_out   (cmp_out)
    );

    // Read copy: reloaded once the slow rising edge is seen in the processor domain
    rtc_sync2 u_slow_sync (
        .clk   (clk_cpu),
        .rst_n (rst_n),
        .d     (clk_slow),
        .q     (slow_s)
    );

    always_ff @(posedge clk_cpu or negedge rst_n) begin
        if (!rst_n) begin
            slow_prev <= 1'b0;
            rd_copy   <= '0;
        end else begin
            slow_prev <= slow_s;
            if (slow_s && !slow_prev) rd_copy <= cnt_q;
        end
    end

    assign count_rd = async_mode ? rd_copy : cnt_q;

    rtc_flag_unit u_ovf_flag (
        .clk     (clk_cpu),
        .rst_n   (rst_n),
        .evt_tgl (ovf_tgl),
        .clr_w1  (flag_clr_ovf),
        .ack     (irq_ack_ovf),
        .flag    (flag_ovf)
    );

    rtc_flag_unit u_cmp_flag (
        .clk     (clk_cpu),
        .rst_n   (rst_n),
        .evt_tgl (cmp_tgl),
        .clr_w1  (flag_clr_cmp),
        .ack     (irq_ack_cmp),
        .flag    (flag_cmp)
    );

    assign irq_ovf = gie && ie_ovf && flag_ovf;
    assign irq_cmp = gie && ie_cmp && flag_cmp;
endmodule

// File: rtl/rtc_async_timer_chk.sv
module rtc_async_timer_chk (
    input logic       clk_cpu,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] wr_sel,
    input logic       busy_cnt,
    input logic       flag_ovf,
    input logic       flag_cmp,
    input logic       flag_clr_ovf,
    input logic       flag_clr_cmp,
    input logic       irq_ack_ovf,
    input logic       irq_ack_cmp,
    input logic       gie,
    input logic       irq_ovf,
    input logic       irq_cmp
);
    assert_busy_set_R2: assert property (@(posedge clk_cpu) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0 && !busy_cnt) |=> busy_cnt);

    assert_ovf_clear_src_R8: assert property (@(posedge clk_cpu) disable iff (!rst_n)
        $fell(flag_ovf) |-> $past(flag_clr_ovf || irq_ack_ovf));

    assert_cmp_clear_src_R8: assert property (@(posedge clk_cpu) disable iff (!rst_n)
        $fell(flag_cmp) |-> $past(flag_clr_cmp || irq_ack_cmp));

    assert_cmp_flag_holds_R6: assert property (@(posedge clk_cpu) disable iff (!rst_n)
        (flag_cmp && !flag_clr_cmp && !irq_ack_cmp) |=> flag_cmp);

    assert_no_irq_without_gie_R9: assert property (@(posedge clk_cpu) disable iff (!rst_n)
        !gie |-> !(irq_ovf || irq_cmp));
endmodule

bind rtc_async_timer rtc_async_timer_chk u_chk (
    .clk_cpu      (clk_cpu),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .busy_cnt     (busy_cnt),
    .flag_ovf     (flag_ovf),
    .flag_cmp     (flag_cmp),
    .flag_clr_ovf (flag_clr_ovf),
    .flag_clr_cmp (flag_clr_cmp),
    .irq_ack_ovf  (irq_ack_ovf),
    .irq_ack_cmp  (irq_ack_cmp),
    .gie          (gie),
    .irq_ovf      (irq_ovf),
    .irq_cmp      (irq_cmp)
);

// File: tb/rtc_async_timer_bench.sv
module rtc_async_timer_bench;
    logic       clk = 1'b0;
    logic       clk_slow = 1'b0;
    logic       slow_en = 1'b1;
    logic       rst_n = 1'b0;
    logic       async_mode = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] count_rd;
    logic       busy_cnt, busy_cmp, busy_ctl;
    logic       flag_clr_ovf = 1'b0, flag_clr_cmp = 1'b0;
    logic       irq_ack_ovf = 1'b0, irq_ack_cmp = 1'b0;
    logic       gie = 1'b0, ie_ovf = 1'b0, ie_cmp = 1'b0;
    logic       flag_ovf, flag_cmp, irq_ovf, irq_cmp, cmp_out;

    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;
    logic [7:0] exp_q[$];
    int         div = 0;

    always #4 clk = ~clk;   // 125 MHz

    // Slow clock: period of 32 processor cycles, edges on processor falling edges
    always @(negedge clk) begin
        if (div == 15) begin
            div <= 0;
            if (slow_en || clk_slow) clk_slow <= ~clk_slow;
        end else begin
            div <= div + 1;
        end
    end

    rtc_async_timer u_rtc_async_timer (
        .clk_cpu(clk), .clk_slow(clk_slow), .rst_n(rst_n), .async_mode(async_mode),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .count_rd(count_rd),
        .busy_cnt(busy_cnt), .busy_cmp(busy_cmp), .busy_ctl(busy_ctl),
        .flag_clr_ovf(flag_clr_ovf), .flag_clr_cmp(flag_clr_cmp),
        .irq_ack_ovf(irq_ack_ovf), .irq_ack_cmp(irq_ack_cmp),
        .gie(gie), .ie_ovf(ie_ovf), .ie_cmp(ie_cmp),
        .flag_ovf(flag_ovf), .flag_cmp(flag_cmp), .irq_ovf(irq_ovf),
        .irq_cmp(irq_cmp), .cmp_out(cmp_out)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_cnt || busy_cmp || busy_ctl) @(negedge clk);
    endtask

    task automatic wait_slow(input int n, input int after);
        repeat (n) @(posedge clk_slow);
        repeat (after) @(negedge clk);
    endtask

    // Scoreboard monitor: one expected read value per slow edge, sampled mid-period
    initial begin
        forever begin
            @(posedge clk_slow);
            repeat (16) @(negedge clk);
            if (exp_q.size() > 0) begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(count_rd == e, "R4/R5 count step", count_rd, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (5) @(negedge clk);
        check(count_rd == 0 && !flag_ovf && !flag_cmp && !cmp_out, "R1 reset outputs",
              {flag_ovf, flag_cmp, cmp_out, count_rd}, 0);
        check(!busy_cnt && !busy_cmp && !busy_ctl && !irq_ovf && !irq_cmp, "R1 reset busy/irq",
              {busy_cnt, busy_cmp, busy_ctl, irq_ovf, irq_cmp}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(count_rd == 0 && !busy_cnt, "R1 after release", count_rd, 0);

        do_write(2'd0, 8'hF0);
        check(busy_cnt == 1'b1, "R2 busy raised", busy_cnt, 1);
        wait_idle();
        check(busy_cnt == 1'b0, "R2 busy cleared", busy_cnt, 0);
        repeat (4) @(negedge clk);
        check(count_rd == 8'hF0, "R4 stopped load", count_rd, 8'hF0);

        // R3: second compare write while busy must be dropped
        do_write(2'd1, 8'hF4);
        do_write(2'd1, 8'h10);
        check(busy_cmp == 1'b1, "R3 still busy with first", busy_cmp, 1);
        wait_idle();

        gie = 1'b1; ie_cmp = 1'b1; ie_ovf = 1'b0;
        do_write(2'd2, 8'h03);
        wait_idle();
        repeat (16) @(negedge clk);
        for (int k = 1; k <= 17; k++) exp_q.push_back(8'(8'hF0 + k));

        wait_slow(3, 2);
        check(flag_cmp == 1'b0, "R6 no flag before match", flag_cmp, 0);
        wait_slow(1, 2);
        check(flag_cmp == 1'b0, "R6 flag not before 3 cycles", flag_cmp, 0);
        check(cmp_out == 1'b1, "R10 cmp_out ahead of flag", cmp_out, 1);
        repeat (2) @(negedge clk);
        check(flag_cmp == 1'b1, "R6/R3 flag at compare 0xF4", flag_cmp, 1);
        check(irq_cmp == 1'b1, "R9 irq_cmp enabled", irq_cmp, 1);
        @(negedge clk);
        flag_clr_cmp = 1'b1;
        @(negedge clk);
        flag_clr_cmp = 1'b0;
        check(flag_cmp == 1'b0 && irq_cmp == 1'b0, "R8 write-one clear", flag_cmp, 0);

        wait_slow(11, 2);
        check(flag_ovf == 1'b0, "R7 no overflow before wrap", flag_ovf, 0);
        wait_slow(1, 4);
        check(flag_ovf == 1'b1, "R7 overflow on wrap", flag_ovf, 1);
        check(irq_ovf == 1'b0, "R9 masked by ie_ovf", irq_ovf, 0);
        ie_ovf = 1'b1;
        @(negedge clk);
        check(irq_ovf == 1'b1, "R9 irq_ovf enabled", irq_ovf, 1);
        gie = 1'b0;
        @(negedge clk);
        check(irq_ovf == 1'b0, "R9 masked by gie", irq_ovf, 0);
        gie = 1'b1;
        irq_ack_ovf = 1'b1;
        @(negedge clk);
        irq_ack_ovf = 1'b0;
        check(flag_ovf == 1'b0, "R8 ack clear", flag_ovf, 0);

        // R4: load while running, no increment on the load edge
        wait_slow(2, 20);
        do_write(2'd0, 8'h40);
        wait_idle();
        repeat (8) @(negedge clk);
        check(count_rd == 8'h40, "R4 running load", count_rd, 8'h40);
        repeat (8) @(negedge clk);
        exp_q.push_back(8'h41);
        exp_q.push_back(8'h42);

        // R5: pause the slow clock
        wait_slow(2, 20);
        @(negedge clk_slow);
        slow_en = 1'b0;
        v = count_rd;
        repeat (200) @(negedge clk);
        check(count_rd == v, "R5 hold while paused", count_rd, v);
        slow_en = 1'b1;
        wait_slow(1, 8);
        check(count_rd == 8'(v + 1), "R5 refresh after resume", count_rd, 8'(v + 1));

        // R11: synchronous mode
        @(negedge clk);
        async_mode = 1'b0;
        repeat (4) @(negedge clk);
        v = count_rd;
        repeat (10) @(negedge clk);
        check(count_rd == 8'(v + 10), "R11 count on cpu clock", count_rd, 8'(v + 10));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule